// File: doc/BRIEF.md
# Composite Phase Dither Source with Matched Boxcar Smoother

This block produces a phase-dither word meant to be summed into the phase accumulator of a digital PLL's numerically controlled oscillator, spreading the quantisation of edge timing so the loop responds more evenly. The word has two fields. The upper field is a short deterministic cycle from a wrapping up-counter. The lower field is pseudo-random noise from a maximal-length LFSR whose period is far longer than the counter's cycle.

The same block smooths the PLL's operating-point word with a moving-average filter. The filter's length equals the period of the cyclic field. Its transfer nulls therefore fall exactly on the dither cycle's fundamental and all of its harmonics. One enable gates both the dither update and the filter sample, so the two stay aligned. When the enable is low, all state holds its value.

Top module: `phase_dither_smoother`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) `dither_o` equals `{0, SEED}`, which is 12'h001 with the defaults. `avg_o` is 0 and `avg_valid_o` is 0.
- R2: At each rising edge where `en` is high, the cyclic field `dither_o[11:8]` increases by one modulo 16.
- R3: At each rising edge where `en` is high, the noise field `dither_o[7:0]` becomes `{q[6:0], q[7]^q[5]^q[4]^q[3]}`, where `q` is its previous value.
- R4: The noise field is never zero. It comes back to its seed value every 255 enabled updates.
- R5: At an edge where `en` is low, `dither_o`, `avg_o` and `avg_valid_o` all keep their values, whatever `op_i` is.
- R6: After each enabled edge, `avg_o` equals the sum of the last 16 accepted `op_i` samples, divided by 16 and rounded down. Slots not yet filled since reset count as zero.
- R7: `avg_valid_o` goes high at the 16th accepted sample after reset. It then stays high until the next reset.
- R8: With a constant input, `avg_o` equals that input once valid, including the full-scale value 16'hFFFF, with no overflow.
- R9: An input that repeats with period 16 gives an `avg_o` that is constant once valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the dither and accepts an `op_i` sample |
| op_i | input | 16 | Raw operating-point word from the PLL |
| dither_o | output | 12 | Dither word: cyclic field [11:8], noise field [7:0] |
| avg_o | output | 16 | Smoothed operating point |
| avg_valid_o | output | 1 | Filter has been filled once since reset |

## Verification
Every output comes straight from a register. The dither word, the average and the valid flag therefore all reflect an enabled edge in the same cycle, one clock after `en` and `op_i` were presented. The bench changes inputs on the falling edge and lets exactly one rising edge pass. It then updates its own model and compares all three outputs at the next falling edge. Cycles with `en` low are checked the same way, and there the expected values are the unchanged ones.

// File: rtl/dith_pkg.sv
package dith_pkg;
   typedef enum logic [1:0] {TAPS_W8, TAPS_W16, TAPS_NONE} lfsr_taps_e;

   function automatic lfsr_taps_e taps_for(input int w);
      if (w == 8)  return TAPS_W8;
      if (w == 16) return TAPS_W16;
      return TAPS_NONE;
   endfunction
endpackage

// File: rtl/dith_cycle_cnt.sv
module dith_cycle_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (rst)      cnt_o <= '0;
      else if (adv) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/dith_lfsr.sv
module dith_lfsr
   import dith_pkg::*;
#(
   parameter int         W    = 8,
   parameter logic [W-1:0] SEED = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] q_o
);
   localparam lfsr_taps_e TAPS = taps_for(W);
   logic fb;

   generate
      if (TAPS == TAPS_W8) begin : g_w8
         assign fb = q_o[7] ^ q_o[5] ^ q_o[4] ^ q_o[3];
      end else if (TAPS == TAPS_W16) begin : g_w16
         assign fb = q_o[15] ^ q_o[14] ^ q_o[12] ^ q_o[3];
      end else begin : g_bad
         assign fb = 1'b0;
         $error("dith_lfsr: unsupported width");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      q_o <= SEED;
      else if (adv) q_o <= {q_o[W-2:0], fb};
   end
endmodule

// File: rtl/dith_boxcar.sv
module dith_boxcar #(
   parameter int DW    = 16,
   parameter int LOG2N = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          take,
   input  logic [DW-1:0] x_i,
   output logic [DW-1:0] avg_o,
   output logic          valid_o
);
   localparam int N  = 1 << LOG2N;
   localparam int SW = DW + LOG2N;

   logic [DW-1:0]    line_q [N];
   logic [LOG2N-1:0] wp_q;
   logic [SW-1:0]    sum_q;
   logic [DW-1:0]    oldest;

   assign oldest = line_q[wp_q];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) line_q[i] <= '0;
         wp_q    <= '0;
         sum_q   <= '0;
         valid_o <= 1'b0;
      end else if (take) begin
         line_q[wp_q] <= x_i;
         wp_q         <= wp_q + 1'b1;
         sum_q        <= sum_q + SW'(x_i) - SW'(oldest);
         if (wp_q == LOG2N'(N - 1)) valid_o <= 1'b1;
      end
   end

   assign avg_o = sum_q[SW-1:LOG2N];
endmodule

// File: rtl/phase_dither_smoother.sv
module phase_dither_smoother #(
   parameter int                CYC_W  = 4,
   parameter int                LFSR_W = 8,
   parameter int                OP_W   = 16,
   parameter logic [LFSR_W-1:0] SEED   = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [OP_W-1:0]         op_i,
   output logic [CYC_W+LFSR_W-1:0] dither_o,
   output logic [OP_W-1:0]         avg_o,
   output logic                    avg_valid_o
);
   generate
      if (CYC_W < 1 || CYC_W > 8) begin : g_bad_cyc
         $error("phase_dither_smoother: CYC_W out of range");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("phase_dither_smoother: SEED must be non-zero");
      end
   endgenerate

   logic [CYC_W-1:0]  cyc;
   logic [LFSR_W-1:0] noise;

   dith_cycle_cnt #(.W(CYC_W)) u_cyc (
      .clk(clk), .rst(rst), .adv(en), .cnt_o(cyc)
   );

   dith_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst(rst), .adv(en), .q_o(noise)
   );

   dith_boxcar #(.DW(OP_W), .LOG2N(CYC_W)) u_box (
      .clk(clk), .rst(rst), .take(en), .x_i(op_i),
      .avg_o(avg_o), .valid_o(avg_valid_o)
   );

   assign dither_o = {cyc, noise};
endmodule

// File: rtl/phase_dither_smoother_chk.sv
module phase_dither_smoother_chk #(
   parameter int CYC_W  = 4,
   parameter int LFSR_W = 8,
   parameter int OP_W   = 16
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    en,
   input logic [CYC_W+LFSR_W-1:0] dither_o,
   input logic [OP_W-1:0]         avg_o,
   input logic                    avg_valid_o
);
   a_r2_cyc_step: assert property (@(posedge clk) disable iff (rst)
      (en && !rst) |=> dither_o[CYC_W+LFSR_W-1:LFSR_W] ==
                       $past(dither_o[CYC_W+LFSR_W-1:LFSR_W]) + 1'b1);

   a_r3_noise_shift: assert property (@(posedge clk) disable iff (rst)
      (en && !rst) |=> dither_o[LFSR_W-1:1] == $past(dither_o[LFSR_W-2:0]));

   a_r4_noise_nonzero: assert property (@(posedge clk) disable iff (rst)
      dither_o[LFSR_W-1:0] != '0);

   a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
      (!en && !rst) |=> ($stable(dither_o) && $stable(avg_o) && $stable(avg_valid_o)));

   a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
      avg_valid_o |=> avg_valid_o);
endmodule

bind phase_dither_smoother phase_dither_smoother_chk #(
   .CYC_W(CYC_W), .LFSR_W(LFSR_W), .OP_W(OP_W)
) u_chk (
   .clk(clk), .rst(rst), .en(en), .dither_o(dither_o),
   .avg_o(avg_o), .avg_valid_o(avg_valid_o)
);

// File: tb/phase_dither_smoother_test.sv
module phase_dither_smoother_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [15:0] op  = '0;
   logic [11:0] dither;
   logic [15:0] avg;
   logic        avg_valid;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   phase_dither_smoother uut (
      .clk(clk), .rst(rst), .en(en), .op_i(op),
      .dither_o(dither), .avg_o(avg), .avg_valid_o(avg_valid)
   );

   // reference model state
   logic [3:0]  m_cyc;
   logic [7:0]  m_lfsr;
   logic [15:0] m_hist [16];
   int          m_wp;
   int          m_taken;

   function automatic logic [7:0] lfsr_adv(input logic [7:0] q);
      return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
   endfunction

   function automatic logic [15:0] exp_avg();
      longint s = 0;
      for (int i = 0; i < 16; i++) s += m_hist[i];
      return 16'(s / 16);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cyc = 0; m_lfsr = 8'h01; m_wp = 0; m_taken = 0;
      for (int i = 0; i < 16; i++) m_hist[i] = '0;
   endtask

   // drive at falling edge, one rising edge, check at next falling edge
   task automatic step(input logic e, input logic [15:0] x, input string req);
      en = e; op = x;
      @(posedge clk);
      if (e) begin
         m_cyc  = m_cyc + 1;
         m_lfsr = lfsr_adv(m_lfsr);
         m_hist[m_wp] = x;
         m_wp = (m_wp + 1) % 16;
         m_taken++;
      end
      @(negedge clk);
      chk({req, " R2 cyclic field"}, 32'(dither[11:8]), 32'(m_cyc));
      chk({req, " R3 noise field"},  32'(dither[7:0]),  32'(m_lfsr));
      chk({req, " R6 average"},      32'(avg),          32'(exp_avg()));
      chk({req, " R7 valid"},        32'(avg_valid),    32'(m_taken >= 16));
      chk("R4 noise non-zero", 32'(dither[7:0] != 0), 32'd1);
      if (e && m_taken % 255 == 0)
         chk("R4 period 255 back to seed", 32'(dither[7:0]), 32'h01);
   endtask

   task automatic do_reset();
      rst = 1'b1; en = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
         end
      end
   end

   initial begin
      logic [11:0] hold_d;
      logic [15:0] hold_a;
      logic [15:0] flat;
      void'($urandom(32'd20240611));

      // R1 reset state
      do_reset();
      chk("R1 dither after reset", 32'(dither), 32'h001);
      chk("R1 avg after reset",    32'(avg),    32'h0);
      chk("R1 valid after reset",  32'(avg_valid), 32'h0);

      // R8 full-scale constant, R7 valid at 16th sample
      for (int i = 0; i < 20; i++) step(1'b1, 16'hFFFF, "R8 full scale");
      chk("R8 full scale average", 32'(avg), 32'hFFFF);
      chk("R7 valid after fill",   32'(avg_valid), 32'd1);

      // R5 enable low freezes everything
      hold_d = dither; hold_a = avg;
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 16'($urandom), "R5 frozen");
         chk("R5 dither held", 32'(dither), 32'(hold_d));
         chk("R5 avg held",    32'(avg),    32'(hold_a));
      end

      // R9 period-16 input gives a flat average
      do_reset();
      for (int i = 0; i < 16; i++) step(1'b1, 16'(i * 3001 + 77), "R9 fill");
      flat = avg;
      for (int i = 0; i < 48; i++) begin
         step(1'b1, 16'((i % 16) * 3001 + 77), "R9 periodic");
         chk("R9 periodic input flat average", 32'(avg), 32'(flat));
      end

      // random stimulus, also spans R4 period checks
      do_reset();
      for (int i = 0; i < 3000; i++)
         step(($urandom % 4) != 0, 16'($urandom), "random");

      // R6 small constant after random history
      for (int i = 0; i < 16; i++) step(1'b1, 16'd5, "R6 settle");
      chk("R6 constant five", 32'(avg), 32'd5);

      finish_run();
   end
endmodule